// File: doc/BRIEF.md
# Dual-Accumulator Fractional Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath for 16-bit operands. It holds two 40-bit accumulators. Each accumulator has a 32-bit product field and eight guard bits above it. Every clock it accepts one command. The command carries an operation code, the accumulator it targets, two operands, per-operand signedness, a fractional/integer mode bit, a saturation enable and a signed shift amount. The result is written back to the chosen accumulator at the next clock edge.

The operands are widened to 17 bits, so signed and unsigned 16-bit values share one 17x17 multiplier. In fractional (1.15) mode the product is doubled. The accumulator update is checked against two bounds, the 32-bit product field and the full 40-bit register. Each accumulator keeps sticky flags for both bounds. When saturation is enabled the written value is clamped to the 32-bit signed range. A combinational read-back port returns a rounded 16-bit view of either accumulator.

Top module: `dual_acc_mac`

## Requirements
- R1: After a synchronous active-high reset, both accumulators read zero and all four overflow flags are low.
- R2: Operation code 3'b001 (multiply) loads the selected accumulator with the product, sign-extended to 40 bits. In integer mode this is the plain product of the operands.
- R3: In fractional mode the product is shifted left by one bit. For example, -1.0 times -1.0 (0x8000 by 0x8000) gives 0x0080000000 when saturation is off.
- R4: Operation code 3'b010 adds the product to the selected accumulator. Operation code 3'b011 subtracts the product from it.
- R5: With saturation enabled, a result outside the 32-bit signed range is written as 0x007FFFFFFF if it is positive and 0xFF80000000 if it is negative. With saturation disabled, the low 40 bits of the exact result are written.
- R6: The guard flag of an accumulator (ovf_guard bit = accumulator index) is set when a write's exact result leaves the 32-bit signed range. The flag stays set until that accumulator is cleared.
- R7: The wide flag of an accumulator (ovf_wide bit = accumulator index) is set when a write's exact result leaves the 40-bit signed range. A set wide flag always comes with a set guard flag.
- R8: Operation code 3'b100 zeroes the selected accumulator and clears both of its flags.
- R9: Operation code 3'b101 shifts the selected accumulator arithmetically by the signed shift amount: left when positive, right when negative. Amounts beyond ±16 act as ±16. The result follows the R5 and R6 rules.
- R10: Operation code 3'b000, and the unused codes 3'b110 and 3'b111, change no accumulator or flag. No operation ever changes the accumulator that is not selected.
- R11: rd_data equals (acc >>> 16) + acc[15] for the accumulator chosen by rd_sel. Its low 16 bits are returned as they are when saturation is off. When saturation is on, the value is clamped to 0x7FFF or 0x8000 if it does not fit in 16 signed bits.
- R12: An operand whose unsigned flag is high is zero-extended into the 17-bit multiplier input. Otherwise it is sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code |
| acc_sel | input | 1 | Accumulator written by the operation |
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| a_uns | input | 1 | First operand is unsigned |
| b_uns | input | 1 | Second operand is unsigned |
| frac_en | input | 1 | Fractional (1.15) multiply mode |
| sat_en | input | 1 | Saturate accumulator writes and read-back |
| shamt | input | 6 | Signed shift amount |
| rd_sel | input | 1 | Accumulator shown on rd_data |
| acc_out | output | 80 | Both accumulators, index 0 in the low 40 bits |
| ovf_guard | output | 2 | Sticky 32-bit overflow flag per accumulator |
| ovf_wide | output | 2 | Sticky 40-bit overflow flag per accumulator |
| rd_data | output | 16 | Rounded 16-bit read-back |

## Verification
The bench builds the block with its default parameters: 16-bit operands, eight guard bits, two accumulators and a shift limit of 16. Under these values a few fractional near-full-scale products are enough to cross the 32-bit boundary. The -1.0 squared corner appears directly. A 16-place left shift of a guard-overflowed value reaches the 40-bit limit within one operation, so both flags and both clamp values can be reached in a handful of commands.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int MAX_W = 64;

    typedef enum logic [2:0] {
        OP_NOP = 3'b000,
        OP_MPY = 3'b001,
        OP_MAC = 3'b010,
        OP_MSC = 3'b011,
        OP_CLR = 3'b100,
        OP_SHF = 3'b101
    } mac_op_e;

    typedef struct packed {
        logic guard;
        logic wide;
    } ovf_t;

    typedef struct packed {
        logic wr;
        logic clr;
    } acc_ctl_t;

    // True when v (sign-extended to MAX_W) is representable in w signed bits.
    function automatic logic sfits(input logic [MAX_W-1:0] v, input int w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < MAX_W; i++) begin
            if (i >= w && v[i] != v[w-1]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic is_write(input mac_op_e o);
        return (o == OP_MPY) || (o == OP_MAC) || (o == OP_MSC) || (o == OP_SHF);
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [OP_W-1:0]         a,
    input  logic [OP_W-1:0]         b,
    input  logic                    a_uns,
    input  logic                    b_uns,
    input  logic                    frac,
    output logic signed [ACC_W-1:0] prod
);
    localparam int MW = 2 * OP_W + 2;

    logic signed [OP_W:0]      ax;
    logic signed [OP_W:0]      bx;
    logic signed [MW-1:0]      p;
    logic signed [ACC_W-1:0]   pe;

    always_comb begin
        ax   = {a_uns ? 1'b0 : a[OP_W-1], a};
        bx   = {b_uns ? 1'b0 : b[OP_W-1], b};
        p    = ax * bx;
        pe   = {{(ACC_W-MW){p[MW-1]}}, p};
        prod = frac ? (pe <<< 1) : pe;
    end

endmodule

// File: rtl/mac_shift.sv
module mac_shift #(
    parameter int ACC_W   = 40,
    parameter int SHF_MAX = 16,
    parameter int SH_W    = 6,
    parameter int EXT_W   = 56
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic signed [SH_W-1:0]  amt,
    output logic signed [EXT_W-1:0] res
);
    localparam int MAG_W = $clog2(SHF_MAX + 1);

    logic [MAG_W-1:0]        mag;
    logic                    left;
    logic signed [EXT_W-1:0] ext;
    int                      s;

    always_comb begin
        s    = int'(amt);
        left = (s > 0);
        if (s > SHF_MAX || s < -SHF_MAX) mag = MAG_W'(SHF_MAX);
        else if (s < 0)                  mag = MAG_W'(-s);
        else                             mag = MAG_W'(s);
        ext  = {{(EXT_W-ACC_W){acc[ACC_W-1]}}, acc};
        res  = left ? (ext <<< mag) : (ext >>> mag);
    end

endmodule

// File: rtl/mac_round.sv
module mac_round #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             sat,
    output logic [OP_W-1:0]  rd
);
    localparam int RW = ACC_W - OP_W + 1;

    logic signed [RW-1:0] hi;
    logic signed [RW-1:0] r;
    logic                 fits;

    always_comb begin
        hi   = {acc[ACC_W-1], acc[ACC_W-1:OP_W]};
        r    = hi + $signed({{(RW-1){1'b0}}, acc[OP_W-1]});
        fits = (r[RW-1:OP_W-1] == '0) || (r[RW-1:OP_W-1] == '1);
        if (sat && !fits) rd = r[RW-1] ? {1'b1, {(OP_W-1){1'b0}}} : {1'b0, {(OP_W-1){1'b1}}};
        else              rd = r[OP_W-1:0];
    end

endmodule

// File: rtl/mac_acc_slice.sv
module mac_acc_slice
    import mac_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_ctl_t         ctl,
    input  logic [ACC_W-1:0] din,
    input  ovf_t             ovf_in,
    output logic [ACC_W-1:0] acc,
    output logic             flg_g,
    output logic             flg_w
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            flg_g <= 1'b0;
            flg_w <= 1'b0;
        end else if (ctl.clr) begin
            acc   <= '0;
            flg_g <= 1'b0;
            flg_w <= 1'b0;
        end else if (ctl.wr) begin
            acc   <= din;
            flg_g <= flg_g | ovf_in.guard;
            flg_w <= flg_w | ovf_in.wide;
        end
    end

    // R8: clear empties the register and both flags
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (acc == '0 && !flg_g && !flg_w));

    // R6: guard flag is sticky until a clear
    a_r6_guard_sticky: assert property (@(posedge clk) disable iff (rst)
        (flg_g && !ctl.clr) |=> flg_g);

    // R10: no command, no change
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.wr && !ctl.clr) |=> ($stable(acc) && $stable(flg_g) && $stable(flg_w)));

endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
    import mac_pkg::*;
#(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8,
    parameter int N_ACC   = 2,
    parameter int SHF_MAX = 16,
    localparam int PROD_W = 2 * OP_W,
    localparam int ACC_W  = PROD_W + GUARD_W,
    localparam int EXT_W  = ACC_W + SHF_MAX,
    localparam int SH_W   = $clog2(SHF_MAX + 1) + 1,
    localparam int SEL_W  = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [2:0]                  op,
    input  logic [SEL_W-1:0]            acc_sel,
    input  logic [OP_W-1:0]             a_in,
    input  logic [OP_W-1:0]             b_in,
    input  logic                        a_uns,
    input  logic                        b_uns,
    input  logic                        frac_en,
    input  logic                        sat_en,
    input  logic [SH_W-1:0]             shamt,
    input  logic [SEL_W-1:0]            rd_sel,
    output logic [N_ACC-1:0][ACC_W-1:0] acc_out,
    output logic [N_ACC-1:0]            ovf_guard,
    output logic [N_ACC-1:0]            ovf_wide,
    output logic [OP_W-1:0]             rd_data
);

    mac_op_e                 op_e;
    logic signed [ACC_W-1:0] acc_cur;
    logic signed [ACC_W-1:0] prod;
    logic signed [EXT_W-1:0] shf_res;
    logic signed [EXT_W-1:0] acc_x;
    logic signed [EXT_W-1:0] prod_x;
    logic signed [EXT_W-1:0] exact;
    logic [MAX_W-1:0]        exact64;
    logic [ACC_W-1:0]        pos_lim;
    logic [ACC_W-1:0]        wr_val;
    ovf_t                    ovf;
    logic                    do_wr;
    logic                    do_clr;

    assign op_e    = mac_op_e'(op);
    assign acc_cur = acc_out[acc_sel];

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .a     (a_in),
        .b     (b_in),
        .a_uns (a_uns),
        .b_uns (b_uns),
        .frac  (frac_en),
        .prod  (prod)
    );

    mac_shift #(.ACC_W(ACC_W), .SHF_MAX(SHF_MAX), .SH_W(SH_W), .EXT_W(EXT_W)) u_shift (
        .acc (acc_cur),
        .amt (shamt),
        .res (shf_res)
    );

    always_comb begin
        acc_x  = {{(EXT_W-ACC_W){acc_cur[ACC_W-1]}}, acc_cur};
        prod_x = {{(EXT_W-ACC_W){prod[ACC_W-1]}}, prod};
        case (op_e)
            OP_MPY:  exact = prod_x;
            OP_MAC:  exact = acc_x + prod_x;
            OP_MSC:  exact = acc_x - prod_x;
            OP_SHF:  exact = shf_res;
            default: exact = '0;
        endcase
        exact64   = {{(MAX_W-EXT_W){exact[EXT_W-1]}}, exact};
        ovf.wide  = !sfits(exact64, ACC_W);
        ovf.guard = !sfits(exact64, PROD_W);
        pos_lim   = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};
        if (sat_en && ovf.guard) wr_val = exact[EXT_W-1] ? ~pos_lim : pos_lim;
        else                     wr_val = exact[ACC_W-1:0];
        do_wr  = is_write(op_e);
        do_clr = (op_e == OP_CLR);
    end

    for (genvar i = 0; i < N_ACC; i++) begin : g_acc
        acc_ctl_t ctl_i;
        assign ctl_i.wr  = do_wr  && (acc_sel == SEL_W'(i));
        assign ctl_i.clr = do_clr && (acc_sel == SEL_W'(i));

        mac_acc_slice #(.ACC_W(ACC_W)) u_slice (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl_i),
            .din    (wr_val),
            .ovf_in (ovf),
            .acc    (acc_out[i]),
            .flg_g  (ovf_guard[i]),
            .flg_w  (ovf_wide[i])
        );

        // R5: a saturating write lands inside the 32-bit signed range
        a_r5_sat_in_range: assert property (@(posedge clk) disable iff (rst)
            (sat_en && do_wr && acc_sel == SEL_W'(i)) |=>
            (acc_out[i][ACC_W-1:PROD_W-1] == '0 || acc_out[i][ACC_W-1:PROD_W-1] == '1));

        // R7: the wide flag never stands without the guard flag
        a_r7_wide_has_guard: assert property (@(posedge clk) disable iff (rst)
            ovf_wide[i] |-> ovf_guard[i]);
    end

    mac_round #(.OP_W(OP_W), .ACC_W(ACC_W)) u_round (
        .acc (acc_out[rd_sel]),
        .sat (sat_en),
        .rd  (rd_data)
    );

endmodule

// File: tb/tb_dual_acc_mac.sv
module tb_dual_acc_mac;

    localparam int CLK_P = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic [2:0]       op;
    logic [0:0]       acc_sel;
    logic [15:0]      a_in, b_in;
    logic             a_uns, b_uns, frac_en, sat_en;
    logic [5:0]       shamt;
    logic [0:0]       rd_sel;
    logic [1:0][39:0] acc_out;
    logic [1:0]       ovf_guard, ovf_wide;
    logic [15:0]      rd_data;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_acc_mac dut (
        .clk(clk), .rst(rst), .op(op), .acc_sel(acc_sel), .a_in(a_in), .b_in(b_in),
        .a_uns(a_uns), .b_uns(b_uns), .frac_en(frac_en), .sat_en(sat_en),
        .shamt(shamt), .rd_sel(rd_sel), .acc_out(acc_out), .ovf_guard(ovf_guard),
        .ovf_wide(ovf_wide), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] o, input logic s, input logic [15:0] a,
                         input logic [15:0] b, input logic au, input logic bu,
                         input logic fr, input logic sat, input logic [5:0] sh);
        @(negedge clk);
        op = o; acc_sel = s; a_in = a; b_in = b; a_uns = au; b_uns = bu;
        frac_en = fr; sat_en = sat; shamt = sh;
        @(posedge clk);
        #1;
        op = 3'b000; sat_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 acc0", acc_out[0], 40'h0);
        chk("R1 acc1", acc_out[1], 40'h0);
        chk("R1 flags", {36'h0, ovf_guard, ovf_wide}, 40'h0);
    endtask

    task automatic t_mpy_int;
        do_op(3'b001, 1'b0, 16'hFFFD, 16'd1000, 0, 0, 0, 0, 6'd0);
        chk("R2 int mpy -3*1000", acc_out[0], 40'hFFFFFFF448);
        chk("R10 acc1 untouched", acc_out[1], 40'h0);
        chk("R6 no guard flag", {38'h0, ovf_guard}, 40'h0);
    endtask

    task automatic t_unsigned;
        do_op(3'b001, 1'b1, 16'hFFFF, 16'd2, 1, 0, 0, 0, 6'd0);
        chk("R12 uns a*2", acc_out[1], 40'h000001FFFE);
        do_op(3'b001, 1'b1, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 6'd0);
        chk("R12 uns*uns", acc_out[1], 40'h00FFFE0001);
        chk("R6 guard set acc1", {38'h0, ovf_guard}, 40'h2);
        do_op(3'b100, 1'b1, 16'h0, 16'h0, 0, 0, 0, 0, 6'd0);
        chk("R8 clear acc1", acc_out[1], 40'h0);
        chk("R8 flags cleared", {36'h0, ovf_guard, ovf_wide}, 40'h0);
    endtask

    task automatic t_frac;
        do_op(3'b001, 1'b0, 16'h4000, 16'h4000, 0, 0, 1, 0, 6'd0);
        chk("R3 half*half", acc_out[0], 40'h0020000000);
        do_op(3'b001, 1'b0, 16'h8000, 16'h8000, 0, 0, 1, 0, 6'd0);
        chk("R3 -1*-1 nosat", acc_out[0], 40'h0080000000);
        chk("R6 guard on -1*-1", {39'h0, ovf_guard[0]}, 40'h1);
        do_op(3'b001, 1'b0, 16'h8000, 16'h8000, 0, 0, 1, 1, 6'd0);
        chk("R5 -1*-1 sat", acc_out[0], 40'h007FFFFFFF);
        do_op(3'b110, 1'b0, 16'h1234, 16'h1234, 0, 0, 0, 0, 6'd0);
        chk("R10 code 110 ignored", acc_out[0], 40'h007FFFFFFF);
        do_op(3'b111, 1'b0, 16'h1234, 16'h1234, 0, 0, 0, 0, 6'd0);
        chk("R10 code 111 ignored", acc_out[0], 40'h007FFFFFFF);
        do_op(3'b100, 1'b0, 16'h0, 16'h0, 0, 0, 0, 0, 6'd0);
    endtask

    task automatic t_mac;
        do_op(3'b001, 1'b1, 16'd100, 16'd200, 0, 0, 0, 0, 6'd0);
        do_op(3'b010, 1'b1, 16'd7, 16'hFFFB, 0, 0, 0, 0, 6'd0);
        chk("R4 mac", acc_out[1], 40'd19965);
        do_op(3'b011, 1'b1, 16'd10, 16'd10, 0, 0, 0, 0, 6'd0);
        chk("R4 msc", acc_out[1], 40'd19865);
        chk("R10 acc0 untouched", acc_out[0], 40'h0);
    endtask

    task automatic t_sat;
        do_op(3'b011, 1'b0, 16'h8000, 16'h7FFF, 0, 0, 1, 1, 6'd0);
        chk("R4 msc frac", acc_out[0], 40'h007FFF0000);
        do_op(3'b011, 1'b0, 16'h8000, 16'h7FFF, 0, 0, 1, 1, 6'd0);
        chk("R5 pos clamp", acc_out[0], 40'h007FFFFFFF);
        do_op(3'b100, 1'b0, 16'h0, 16'h0, 0, 0, 0, 0, 6'd0);
        do_op(3'b010, 1'b0, 16'h8000, 16'h7FFF, 0, 0, 1, 1, 6'd0);
        do_op(3'b010, 1'b0, 16'h8000, 16'h7FFF, 0, 0, 1, 1, 6'd0);
        chk("R5 neg clamp", acc_out[0], 40'hFF80000000);
        do_op(3'b100, 1'b0, 16'h0, 16'h0, 0, 0, 0, 0, 6'd0);
        do_op(3'b011, 1'b0, 16'h8000, 16'h7FFF, 0, 0, 1, 0, 6'd0);
        do_op(3'b011, 1'b0, 16'h8000, 16'h7FFF, 0, 0, 1, 0, 6'd0);
        chk("R5 no-sat keeps guard bits", acc_out[0], 40'h00FFFE0000);
        chk("R6 guard acc0 set", {39'h0, ovf_guard[0]}, 40'h1);
        chk("R7 no wide yet", {38'h0, ovf_wide}, 40'h0);
        do_op(3'b100, 1'b0, 16'h0, 16'h0, 0, 0, 0, 0, 6'd0);
    endtask

    task automatic t_wide;
        do_op(3'b001, 1'b0, 16'h8000, 16'h8000, 0, 0, 1, 0, 6'd0);
        do_op(3'b101, 1'b0, 16'h0, 16'h0, 0, 0, 0, 0, 6'd16);
        chk("R7 wrap to zero", acc_out[0], 40'h0);
        chk("R7 wide acc0", {38'h0, ovf_wide}, 40'h1);
        chk("R6 guard acc0", {38'h0, ovf_guard}, 40'h1);
        do_op(3'b100, 1'b0, 16'h0, 16'h0, 0, 0, 0, 0, 6'd0);
        chk("R8 wide cleared", {38'h0, ovf_wide}, 40'h0);
    endtask

    task automatic t_shift;
        do_op(3'b001, 1'b1, 16'd100, 16'd200, 0, 0, 0, 0, 6'd0);
        do_op(3'b101, 1'b1, 16'h0, 16'h0, 0, 0, 0, 0, 6'd4);
        chk("R9 left 4", acc_out[1], 40'd320000);
        do_op(3'b101, 1'b1, 16'h0, 16'h0, 0, 0, 0, 0, 6'h38);
        chk("R9 right 8", acc_out[1], 40'd1250);
        do_op(3'b001, 1'b1, 16'hFFFD, 16'd1000, 0, 0, 0, 0, 6'd0);
        do_op(3'b101, 1'b1, 16'h0, 16'h0, 0, 0, 0, 0, 6'h3C);
        chk("R9 arith right neg", acc_out[1], 40'hFFFFFFFF44);
        do_op(3'b001, 1'b1, 16'd1, 16'd1, 0, 0, 0, 0, 6'd0);
        do_op(3'b101, 1'b1, 16'h0, 16'h0, 0, 0, 0, 0, 6'd20);
        chk("R9 clamp +20", acc_out[1], 40'h0000010000);
        do_op(3'b101, 1'b1, 16'h0, 16'h0, 0, 0, 0, 0, 6'h2C);
        chk("R9 clamp -20", acc_out[1], 40'h1);
        do_op(3'b001, 1'b1, 16'h4000, 16'h4000, 0, 0, 1, 0, 6'd0);
        do_op(3'b101, 1'b1, 16'h0, 16'h0, 0, 0, 0, 1, 6'd2);
        chk("R9 sat shift", acc_out[1], 40'h007FFFFFFF);
        chk("R9 shift guard flag", {38'h0, ovf_guard}, 40'h2);
        do_op(3'b100, 1'b1, 16'h0, 16'h0, 0, 0, 0, 0, 6'd0);
    endtask

    task automatic t_read;
        do_op(3'b001, 1'b0, 16'h4000, 16'h4000, 0, 0, 1, 0, 6'd0);
        rd_sel = 1'b0; #1;
        chk("R11 plain", {24'h0, rd_data}, 40'h2000);
        do_op(3'b001, 1'b0, 16'd128, 16'd256, 0, 0, 0, 0, 6'd0);
        #1;
        chk("R11 round up", {24'h0, rd_data}, 40'h1);
        do_op(3'b001, 1'b0, 16'hFFFD, 16'd1000, 0, 0, 0, 0, 6'd0);
        #1;
        chk("R11 neg rounds to 0", {24'h0, rd_data}, 40'h0);
        do_op(3'b001, 1'b1, 16'h8000, 16'h8000, 0, 0, 1, 0, 6'd0);
        rd_sel = 1'b1; #1;
        chk("R11 nosat wraps", {24'h0, rd_data}, 40'h8000);
        sat_en = 1'b1; #1;
        chk("R11 sat clamps", {24'h0, rd_data}, 40'h7FFF);
        sat_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op = 3'b000; acc_sel = 1'b0; a_in = '0; b_in = '0;
        a_uns = 0; b_uns = 0; frac_en = 0; sat_en = 0; shamt = '0; rd_sel = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mpy_int();
        t_unsigned();
        t_frac();
        t_mac();
        do_op(3'b100, 1'b1, 16'h0, 16'h0, 0, 0, 0, 0, 6'd0);
        t_sat();
        t_wide();
        t_shift();
        t_read();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule